// File: doc/BRIEF.md
# Four-Channel DMA Register and Address Stepping Unit

This block holds the programming state of four DMA channels behind an 8-bit programmed-I/O host port. Each channel has a 16-bit current address, a 16-bit transfer count, an 8-bit page, a mode and a mask bit. The 16-bit registers are reached through 8-bit accesses. A single shared byte-pointer flip-flop picks the low or the high half, and every access to one of these registers flips it. Dedicated ports clear that flip-flop, mask or unmask one channel, set one channel's mode, and reset the whole controller.

A transfer engine elsewhere in the chip presents a channel number with a step strobe. In the same cycle the block drives the 24-bit physical address of that transfer, formed as {page, current address}. It also drives a terminal-count flag and the transfer direction. On the next clock edge the channel's address moves by one and its count drops by one. The address wraps inside its 64 KiB page and never carries into the page. When the count passes below zero, the channel stops taking steps until its count is rewritten.

Top module: `dma_chan_regs`

## Requirements
- R1: For channel n (0..3), host offset 2n reaches the current address and 2n+1 reaches the count. The shared byte pointer selects the low byte when 0 and the high byte when 1. It inverts after every read or write to offsets 0x00..0x07.
- R2: Any write to offset 0x0C sets the byte pointer to 0, whatever the data.
- R3: A write to offset 0x0A picks channel data[1:0]. data[2]=1 masks that channel and data[2]=0 unmasks it. chan_en[n] is 1 exactly when channel n is unmasked.
- R4: Any write to offset 0x0D sets the byte pointer to 0 and masks all four channels. Hardware reset does the same and also zeroes every address, count, page and mode.
- R5: A write to offset 0x0B picks channel data[1:0] and stores data[7:2] as its mode. While a channel is stepped, xfer_to_mem is 1 when data[3:2]=01 (value 0x44) and 0 when data[3:2]=10 (value 0x48). data[5]=1 makes the address count down instead of up.
- R6: While step_valid is high for an unmasked, unfinished channel, phys_addr = {page, current address} in that cycle. At the next edge the address moves by one in the mode's direction and the count drops by one.
- R7: Stepping the address up from 0xFFFF gives 0x0000, and stepping down from 0x0000 gives 0xFFFF. The page register is never altered by stepping.
- R8: A count programmed as N-1 yields exactly N accepted steps. tc is high in the cycle of the Nth step, and the count then reads back 0xFFFF.
- R9: After its terminal step a channel ignores steps (no tc, no address change) until a byte of its count register is written.
- R10: The page registers for channels 0, 1, 2 and 3 sit at offsets 0x87, 0x83, 0x81 and 0x82. They are written and read there and supply phys_addr[23:16].
- R11: A low-byte read of an address or count register captures the whole 16-bit value. The following high-byte read returns the captured high byte even if the register has changed in between.
- R12: Steps to a masked channel are ignored: tc stays 0 and the address and count keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host port offset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid while host_rd is high |
| step_valid | input | 1 | Transfer step request |
| step_chan | input | 2 | Channel to be stepped |
| phys_addr | output | 24 | Physical address of the stepped channel |
| tc | output | 1 | Terminal count of the accepted step |
| chan_en | output | 4 | Per-channel enabled (unmasked) status |
| xfer_to_mem | output | 1 | Direction of the stepped channel, 1 = I/O to memory |

## Verification
The bound checker watches the byte-pointer behaviour on every cycle: it must invert on each register access and clear after the clear and reset ports. It also checks that a master reset masks every channel, and that tc only appears with a zero count on an enabled channel. It confirms that masked or finished channels hold their address and count, and that an upward step from 0xFFFF lands on 0x0000. Page preservation across a wrap and the exact N-transfer count need the bench's scenarios. So do the register offsets, the page port map and the direction encodings of the mode values, along with the capture of a 16-bit value across two reads while the register keeps stepping.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_ADDR,
    K_CNT,
    K_MASK,
    K_MODE,
    K_CLRFF,
    K_MRST,
    K_PAGE
  } port_kind_e;

  localparam logic [7:0] OFS_MASK  = 8'h0A;
  localparam logic [7:0] OFS_MODE  = 8'h0B;
  localparam logic [7:0] OFS_CLRFF = 8'h0C;
  localparam logic [7:0] OFS_MRST  = 8'h0D;

  // page port of a channel; the order is irregular, so it is a lookup
  function automatic logic [7:0] page_port(input int unsigned ch);
    case (ch)
      0: page_port = 8'h87;
      1: page_port = 8'h83;
      2: page_port = 8'h81;
      3: page_port = 8'h82;
      default: page_port = 8'h88 + 8'(ch);
    endcase
  endfunction

  // address step inside a 64 KiB page: wraps, never carries out
  function automatic logic [15:0] step_addr(input logic [15:0] a, input logic down);
    step_addr = down ? (a - 16'd1) : (a + 16'd1);
  endfunction

  function automatic logic [15:0] step_count(input logic [15:0] c);
    step_count = c - 16'd1;
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regs_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int HA_W = 8
) (
  input  logic [HA_W-1:0]        host_addr,
  output port_kind_e             kind,
  output logic [$clog2(NCH)-1:0] chan
);
  localparam int CHW = $clog2(NCH);

  always_comb begin
    kind = K_NONE;
    chan = '0;
    if (host_addr < HA_W'(2 * NCH)) begin
      kind = host_addr[0] ? K_CNT : K_ADDR;
      chan = host_addr[CHW:1];
    end else if (host_addr == HA_W'(OFS_MASK)) begin
      kind = K_MASK;
    end else if (host_addr == HA_W'(OFS_MODE)) begin
      kind = K_MODE;
    end else if (host_addr == HA_W'(OFS_CLRFF)) begin
      kind = K_CLRFF;
    end else if (host_addr == HA_W'(OFS_MRST)) begin
      kind = K_MRST;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (host_addr == HA_W'(page_port(i))) begin
          kind = K_PAGE;
          chan = CHW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_regs_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 8,
  parameter int MODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr_page,
  input  logic              wr_mode,
  input  logic              mask_we,
  input  logic              mask_val,
  input  logic              mask_all,
  input  logic              step,
  output logic [CNT_W-1:0]  cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PAGE_W-1:0] page,
  output logic              masked,
  output logic              done,
  output logic              addr_down,
  output logic              to_mem,
  output logic              tc_evt
);
  logic [MODE_W-1:0] mode_q;
  logic              accept;

  // stored mode = host data [7:2]; [3] is data bit 5, [1:0] data bits 3:2
  assign addr_down = mode_q[3];
  assign to_mem    = (mode_q[1:0] == 2'b01);
  assign accept    = step && !masked && !done;
  assign tc_evt    = accept && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      page     <= '0;
      mode_q   <= '0;
      masked   <= 1'b1;
      done     <= 1'b0;
    end else begin
      if (mask_all)      masked <= 1'b1;
      else if (mask_we)  masked <= mask_val;

      if (wr_mode) mode_q <= wdata[BYTE_W-1 -: MODE_W];
      if (wr_page) page   <= wdata[PAGE_W-1:0];

      if (wr_addr) begin
        if (byte_hi) cur_addr[BYTE_W +: BYTE_W] <= wdata;
        else         cur_addr[0 +: BYTE_W]      <= wdata;
      end else if (accept) begin
        cur_addr <= step_addr(cur_addr, addr_down);
      end

      if (wr_cnt) begin
        if (byte_hi) cur_cnt[BYTE_W +: BYTE_W] <= wdata;
        else         cur_cnt[0 +: BYTE_W]      <= wdata;
        done <= 1'b0;
      end else if (accept) begin
        cur_cnt <= step_count(cur_cnt);
        if (cur_cnt == '0) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int HA_W   = 8,
  parameter int BYTE_W = 8,
  parameter int PAGE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [HA_W-1:0]          host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [BYTE_W-1:0]        host_wdata,
  output logic [BYTE_W-1:0]        host_rdata,
  input  logic                     step_valid,
  input  logic [$clog2(NCH)-1:0]   step_chan,
  output logic [2*BYTE_W+PAGE_W-1:0] phys_addr,
  output logic                     tc,
  output logic [NCH-1:0]           chan_en,
  output logic                     xfer_to_mem
);
  localparam int CHW   = $clog2(NCH);
  localparam int CNT_W = 2 * BYTE_W;

  port_kind_e             kind;
  logic [CHW-1:0]         dchan;
  logic                   is_reg;
  logic                   ff_q;
  logic [CNT_W-1:0]       hold_q;
  logic [CNT_W-1:0]       sel_val;
  logic [CHW-1:0]         data_chan;

  logic [NCH-1:0][CNT_W-1:0]  addr_v;
  logic [NCH-1:0][CNT_W-1:0]  cnt_v;
  logic [NCH-1:0][PAGE_W-1:0] page_v;
  logic [NCH-1:0]             masked_v;
  logic [NCH-1:0]             done_v;
  logic [NCH-1:0]             dec_v;
  logic [NCH-1:0]             tomem_v;
  logic [NCH-1:0]             tc_v;

  dma_port_decode #(.NCH(NCH), .HA_W(HA_W)) u_dec (
    .host_addr (host_addr),
    .kind      (kind),
    .chan      (dchan)
  );

  assign is_reg    = (kind == K_ADDR) || (kind == K_CNT);
  assign data_chan = host_wdata[CHW-1:0];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_channel #(
        .CNT_W (CNT_W),
        .BYTE_W(BYTE_W),
        .PAGE_W(PAGE_W),
        .MODE_W(BYTE_W - 2)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_addr  (host_wr && kind == K_ADDR && dchan == CHW'(i)),
        .wr_cnt   (host_wr && kind == K_CNT  && dchan == CHW'(i)),
        .byte_hi  (ff_q),
        .wdata    (host_wdata),
        .wr_page  (host_wr && kind == K_PAGE && dchan == CHW'(i)),
        .wr_mode  (host_wr && kind == K_MODE && data_chan == CHW'(i)),
        .mask_we  (host_wr && kind == K_MASK && data_chan == CHW'(i)),
        .mask_val (host_wdata[2]),
        .mask_all (host_wr && kind == K_MRST),
        .step     (step_valid && step_chan == CHW'(i)),
        .cur_addr (addr_v[i]),
        .cur_cnt  (cnt_v[i]),
        .page     (page_v[i]),
        .masked   (masked_v[i]),
        .done     (done_v[i]),
        .addr_down(dec_v[i]),
        .to_mem   (tomem_v[i]),
        .tc_evt   (tc_v[i])
      );
    end
  endgenerate

  // shared byte pointer: 0 = low byte next, 1 = high byte next
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else if (host_wr && (kind == K_CLRFF || kind == K_MRST)) begin
      ff_q <= 1'b0;
    end else if ((host_wr || host_rd) && is_reg) begin
      ff_q <= ~ff_q;
    end
  end

  assign sel_val = (kind == K_CNT) ? cnt_v[dchan] : addr_v[dchan];

  // the low-byte read freezes the whole value for the high-byte read
  always_ff @(posedge clk) begin
    if (!rst_n)                         hold_q <= '0;
    else if (host_rd && is_reg && !ff_q) hold_q <= sel_val;
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd) begin
      if (is_reg)             host_rdata = ff_q ? hold_q[BYTE_W +: BYTE_W] : sel_val[0 +: BYTE_W];
      else if (kind == K_PAGE) host_rdata = BYTE_W'(page_v[dchan]);
    end
  end

  assign phys_addr   = {page_v[step_chan], addr_v[step_chan]};
  assign tc          = |tc_v;
  assign chan_en     = ~masked_v;
  assign xfer_to_mem = tomem_v[step_chan];

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NCH    = 4,
  parameter int HA_W   = 8,
  parameter int CNT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [HA_W-1:0]           host_addr,
  input logic                      host_wr,
  input logic                      host_rd,
  input logic                      step_valid,
  input logic [$clog2(NCH)-1:0]    step_chan,
  input logic                      tc,
  input logic [NCH-1:0]            chan_en,
  input logic                      ff_q,
  input logic [NCH-1:0][CNT_W-1:0] addr_v,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v,
  input logic [NCH-1:0]            done_v,
  input logic [NCH-1:0]            dec_v
);
  logic reg_access;
  logic step_ok;
  assign reg_access = (host_wr || host_rd) && (host_addr < HA_W'(2 * NCH));
  assign step_ok    = step_valid && chan_en[step_chan] && !done_v[step_chan];

  p_ff_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_access |=> (ff_q != $past(ff_q)));

  p_clr_ff_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == HA_W'(8'h0C)) |=> !ff_q);

  p_master_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == HA_W'(8'h0D)) |=> (chan_en == '0 && !ff_q));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !host_wr && !dec_v[step_chan] && addr_v[step_chan] == '1)
      |=> (addr_v[$past(step_chan)] == '0));

  p_tc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (step_valid && chan_en[step_chan] && cnt_v[step_chan] == '0));

  p_done_after_tc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !host_wr) |=> done_v[$past(step_chan)]);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && done_v[step_chan] && !host_wr) |=> ($stable(addr_v) && $stable(cnt_v)));

  p_masked_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !chan_en[step_chan] && !host_wr) |=> ($stable(addr_v) && $stable(cnt_v)));

  p_masked_no_tc_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !chan_en[step_chan]) |-> !tc);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .HA_W(HA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_addr (host_addr),
  .host_wr   (host_wr),
  .host_rd   (host_rd),
  .step_valid(step_valid),
  .step_chan (step_chan),
  .tc        (tc),
  .chan_en   (chan_en),
  .ff_q      (ff_q),
  .addr_v    (addr_v),
  .cnt_v     (cnt_v),
  .done_v    (done_v),
  .dec_v     (dec_v)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        step_valid = 1'b0;
  logic [1:0]  step_chan = '0;
  logic [23:0] phys_addr;
  logic        tc;
  logic [3:0]  chan_en;
  logic        xfer_to_mem;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .step_valid(step_valid), .step_chan(step_chan), .phys_addr(phys_addr),
    .tc(tc), .chan_en(chan_en), .xfer_to_mem(xfer_to_mem)
  );

  function automatic logic [7:0] pg_port(input int ch);
    logic [7:0] tbl [4] = '{8'h87, 8'h83, 8'h81, 8'h82};
    return tbl[ch];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic rd16(input logic [7:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a, hi);
    v = {hi, lo};
  endtask

  task automatic wr16(input logic [7:0] a, input logic [15:0] v);
    wr(a, v[7:0]);
    wr(a, v[15:8]);
  endtask

  // step and check tc / phys / direction in the step cycle
  task automatic step(input int ch, input logic [23:0] exp_pa, input logic exp_tc,
                      input logic exp_mem, input string req);
    @(negedge clk);
    step_valid = 1'b1; step_chan = 2'(ch);
    #1;
    check({req, " phys"}, 32'(phys_addr), 32'(exp_pa));
    check({req, " tc"}, 32'(tc), 32'(exp_tc));
    check({req, " dir"}, 32'(xfer_to_mem), 32'(exp_mem));
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  task automatic step_quiet(input int ch, input string req);
    @(negedge clk);
    step_valid = 1'b1; step_chan = 2'(ch);
    #1 check({req, " ignored tc"}, 32'(tc), 32'h0);
    @(negedge clk);
    step_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state (R4)
    #1 check("R4 reset chan_en", 32'(chan_en), 32'h0);
    rd16(8'h00, v);  check("R4 reset addr0", 32'(v), 32'h0);
    rd(pg_port(2), b); check("R4 reset page2", 32'(b), 32'h0);

    // per-channel sweep: program, run N steps, finish (R1 R5 R6 R8 R9 R10)
    for (int n = 0; n < 4; n++) begin
      logic [15:0] base;
      logic [7:0]  pg;
      int          nx;
      base = 16'h2000 + 16'(n) * 16'h0111;
      pg   = 8'h10 + 8'(n);
      nx   = 2 + n;
      wr(8'h0C, 8'h00);
      wr16(8'(2 * n), base);
      wr16(8'(2 * n + 1), 16'(nx - 1));
      wr(pg_port(n), pg);
      wr(8'h0B, 8'h44 | 8'(n));
      wr(8'h0A, 8'(n));
      #1 check("R3 unmask", 32'(chan_en[n]), 32'h1);
      rd(pg_port(n), b); check("R10 page readback", 32'(b), 32'(pg));
      for (int i = 0; i < nx; i++)
        step(n, {pg, base + 16'(i)}, (i == nx - 1), 1'b1, "R6 R8 R10 step");
      step_quiet(n, "R9");
      rd16(8'(2 * n + 1), v); check("R8 count after done", 32'(v), 32'hFFFF);
      rd16(8'(2 * n), v);     check("R9 addr held", 32'(v), 32'(base + 16'(nx)));
    end

    // R9: rewriting the count re-arms channel 0 (count 0 -> one transfer)
    wr16(8'h01, 16'h0000);
    step(0, {8'h10, 16'h2002}, 1'b1, 1'b1, "R9 rearm");

    // R12 R3: masked channel ignores steps
    wr16(8'h03, 16'h0004);
    wr(8'h0A, 8'h05);
    #1 check("R3 mask ch1", 32'(chan_en[1]), 32'h0);
    step_quiet(1, "R12");
    rd16(8'h02, v); check("R12 addr kept", 32'(v), 32'h2114);
    rd16(8'h03, v); check("R12 count kept", 32'(v), 32'h0004);
    wr(8'h0A, 8'h01);
    step(1, {8'h11, 16'h2114}, 1'b0, 1'b1, "R3 unmasked step");

    // R7: wrap inside the page while counting up
    wr16(8'h02, 16'hFFFE);
    for (int i = 0; i < 3; i++)
      step(1, {8'h11, 16'hFFFE + 16'(i)}, 1'b0, 1'b1, "R7 up wrap");
    rd16(8'h02, v); check("R7 addr after wrap", 32'(v), 32'h0001);
    rd(pg_port(1), b); check("R7 page kept", 32'(b), 32'h11);

    // R5 R7: mode 0x48 + down (0x6A = ch2), four transfers through 0
    wr(8'h0B, 8'h6A);
    wr16(8'h04, 16'h0001);
    wr16(8'h05, 16'h0003);
    for (int i = 0; i < 4; i++)
      step(2, {8'h12, 16'h0001 - 16'(i)}, (i == 3), 1'b0, "R5 R7 down");
    rd16(8'h04, v); check("R5 addr after down", 32'(v), 32'hFFFD);

    // R2: clear pointer after a stray low-byte write
    wr(8'h00, 8'h12);
    wr(8'h0C, 8'hFF);
    wr16(8'h00, 16'h5634);
    rd16(8'h00, v); check("R2 clear pointer", 32'(v), 32'h5634);

    // R11: value captured on low read, register steps before high read
    wr16(8'h07, 16'h0100);
    wr(8'h0A, 8'h03);
    rd(8'h07, b); check("R11 low byte", 32'(b), 32'h00);
    step(3, {8'h13, 16'h2333 + 16'd5}, 1'b0, 1'b1, "R11 step between");
    rd(8'h07, b); check("R11 captured high", 32'(b), 32'h01);
    rd16(8'h07, v); check("R11 fresh read", 32'(v), 32'h00FF);

    // R4: master reset clears pointer and masks all
    wr(8'h00, 8'hAB);
    wr(8'h0D, 8'h00);
    #1 check("R4 master mask", 32'(chan_en), 32'h0);
    wr16(8'h00, 16'hEFCD);
    rd16(8'h00, v); check("R4 pointer cleared", 32'(v), 32'hEFCD);
    step_quiet(3, "R4 R12 after master reset");

    // R1: address and count registers are separate per channel
    wr16(8'h06, 16'hA55A);
    rd16(8'h07, v); check("R1 count untouched", 32'(v), 32'h00FF);
    rd16(8'h06, v); check("R1 addr ch3", 32'(v), 32'hA55A);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule